// File: doc/BRIEF.md
# Descriptor-Driven Scatter Engine

The engine sits inside a switch fabric with `NP` ports and moves a bulk submission from each ingress lane to the other ports without copying or combining data. A submission starts with one descriptor word that holds a destination tag for each chunk. It is followed by `NP-1` payload chunks of `CW` words each, because a port's own chunk never crosses the fabric. The engine reads the tag of the current chunk and streams the chunk's words to the named egress lane. Each output word carries the ID of the ingress port that sent it.

Every ingress lane may submit at the same time. Each egress lane has its own round-robin arbiter. A grant lasts for one whole chunk, so chunks from different sources never mix on an egress lane. Chunks bound for different egress lanes move in the same cycle. A chunk whose tag is invalid is consumed and thrown away, and an error pulse marks it. A done pulse marks the end of each submission.

Top module: `scatter_engine`

## Requirements
- R1: After reset, every `out_valid`, `done` and `err` bit is 0 and every `in_ready` bit is 1.
- R2: On an idle lane, the first accepted word (`in_valid` and `in_ready` both high) is the descriptor. The tag for chunk k sits in bits [k*TW +: TW], with TW = clog2(NP)+1. The descriptor is followed by NP-1 chunks of CW accepted words each, and chunk k is the k-th of these.
- R3: A word of chunk k appears on egress lane tag[k] one clock edge after it is accepted. The data is unchanged, `out_src` holds the ingress port number, and the words of a source reach that egress in the order they were accepted.
- R4: Each accepted payload word with a valid tag appears exactly once, on exactly one egress lane.
- R5: On one egress lane, the CW words of a chunk come out as one contiguous run with no other source's words between them. When several sources are waiting for the same egress, the chunk grants rotate round-robin in ascending port order, wrapping around and starting after the previous owner. After reset the search starts at port 0.
- R6: A chunk whose tag equals its own source port, or is NP or larger, is accepted at full rate and appears on no egress lane. Its source's `err` bit pulses high for one cycle after the chunk's last word is accepted.
- R7: A source's `done` bit pulses high for one cycle after the last word of its last chunk is accepted. If that chunk is forwarded, this is the same cycle its last word is on the egress lane.
- R8: Chunks from different sources that go to different egress lanes move in the same cycles, at one word per cycle on each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NP | Word present on each ingress lane |
| in_data | input | NP*W | Ingress words; lane p uses bits [p*W +: W] |
| in_ready | output | NP | Ingress lane may take a word this cycle |
| out_valid | output | NP | Word present on each egress lane |
| out_data | output | NP*W | Egress words; lane p uses bits [p*W +: W] |
| out_src | output | NP*SW | Source port of each egress word, SW = clog2(NP) |
| done | output | NP | Submission on that ingress lane has completed |
| err | output | NP | Chunk on that ingress lane was dropped for a bad tag |

## Verification
Four submissions are tried, and each one targets a different failure.

1. A rotating pattern sends every chunk index of every source to a different egress. A wrong tag field, lost parallelism or duplicated words all show up here.
2. Three sources aim every chunk at one egress. This checks the order of the round-robin grants and that whole chunks stay together.
3. A descriptor mixes a self tag, a valid tag and an out-of-range tag. This separates dropping from forwarding and checks the error count.
4. A lone submission compares the cycle of the done pulse with the cycle the last word appears on the egress lane.

// File: rtl/scatter_engine.sv
module scatter_engine #(
  parameter int NP = 4,
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*W-1:0]  in_data,
  output logic [NP-1:0]    in_ready,
  output logic [NP-1:0]    out_valid,
  output logic [NP*W-1:0]  out_data,
  output logic [NP*$clog2(NP)-1:0] out_src,
  output logic [NP-1:0]    done,
  output logic [NP-1:0]    err
);
  localparam int SW  = $clog2(NP);
  localparam int TW  = SW + 1;
  localparam int DW  = (NP-1) * TW;
  localparam int CKW = $clog2(NP);
  localparam int WDW = $clog2(CW+1);

  logic [W-1:0]   din   [NP];
  logic [DW-1:0]  tags  [NP];
  logic [CKW-1:0] chk   [NP];
  logic [WDW-1:0] wrd   [NP];
  logic [TW-1:0]  ctag  [NP];
  logic [NP-1:0]  req   [NP];
  logic [NP-1:0]  gvec  [NP];
  logic [NP-1:0]  phase, tok, gnt, acc;
  logic [NP-1:0]  busy, rel, found;
  logic [SW-1:0]  owner [NP];
  logic [SW-1:0]  last  [NP];
  logic [SW-1:0]  pick  [NP];
  logic [W-1:0]   od    [NP];
  logic [SW-1:0]  os    [NP];

  for (genvar s = 0; s < NP; s++) begin : g_src
    assign din[s]  = in_data[s*W +: W];
    assign ctag[s] = tags[s][chk[s]*TW +: TW];
    assign tok[s]  = (ctag[s] < TW'(NP)) && (ctag[s] != TW'(s));
    assign req[s]  = (phase[s] && tok[s]) ? (NP'(1) << ctag[s][SW-1:0]) : '0;
    assign in_ready[s] = !phase[s] || !tok[s] || gnt[s];
    assign acc[s]  = in_valid[s] && in_ready[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phase[s] <= 1'b0; chk[s] <= '0; wrd[s] <= '0;
        tags[s] <= '0; done[s] <= 1'b0; err[s] <= 1'b0;
      end else begin
        done[s] <= 1'b0;
        err[s]  <= 1'b0;
        if (acc[s]) begin
          if (!phase[s]) begin
            tags[s] <= din[s][DW-1:0];
            phase[s] <= 1'b1; chk[s] <= '0; wrd[s] <= '0;
          end else if (wrd[s] == WDW'(CW-1)) begin
            wrd[s] <= '0;
            if (!tok[s]) err[s] <= 1'b1;
            if (chk[s] == CKW'(NP-2)) begin
              phase[s] <= 1'b0;
              done[s] <= 1'b1;
            end else chk[s] <= chk[s] + 1'b1;
          end else wrd[s] <= wrd[s] + 1'b1;
        end
      end
    end

    // R4
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gvec[s]) <= 1);
    // R7
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done[s] |-> $past(acc[s]));
    // R6
    err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err[s] |-> $past(acc[s]) && $past(phase[s]));
  end

  always_comb begin
    for (int s = 0; s < NP; s++) begin
      gnt[s] = 1'b0;
      for (int e = 0; e < NP; e++) begin
        gvec[s][e] = busy[e] && (owner[e] == SW'(s));
        gnt[s] = gnt[s] | gvec[s][e];
      end
    end
    for (int e = 0; e < NP; e++) begin
      pick[e]  = '0;
      found[e] = 1'b0;
      for (int i = 1; i <= NP; i++) begin
        int j;
        j = (int'(last[e]) + i) % NP;
        if (!found[e] && req[j][e]) begin
          found[e] = 1'b1;
          pick[e]  = SW'(j);
        end
      end
      rel[e] = busy[e] && acc[owner[e]] && (wrd[owner[e]] == WDW'(CW-1));
    end
  end

  for (genvar e = 0; e < NP; e++) begin : g_egr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[e] <= 1'b0; owner[e] <= '0; last[e] <= SW'(NP-1);
        out_valid[e] <= 1'b0; od[e] <= '0; os[e] <= '0;
      end else begin
        out_valid[e] <= busy[e] && acc[owner[e]];
        od[e] <= din[owner[e]];
        os[e] <= owner[e];
        if (busy[e]) begin
          if (rel[e]) busy[e] <= 1'b0;
        end else if (found[e]) begin
          busy[e] <= 1'b1; owner[e] <= pick[e]; last[e] <= pick[e];
        end
      end
    end
    assign out_data[e*W +: W]  = od[e];
    assign out_src[e*SW +: SW] = os[e];

    // R6
    no_self_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[e] |-> (os[e] != SW'(e)));
    // R5
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[e] && !rel[e]) |=> (busy[e] && $stable(owner[e])));
  end
endmodule

// File: tb/sim_scatter_engine.sv
module sim_scatter_engine;
  localparam int NP = 4, W = 16, CW = 3, SW = 2, TW = 3;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [NP-1:0] v = '0;
  logic [W-1:0]  d [NP];
  logic [NP*W-1:0] in_data;
  logic [NP-1:0] in_ready, out_valid, done, err;
  logic [NP*W-1:0] out_data;
  logic [NP*SW-1:0] out_src;
  for (genvar s = 0; s < NP; s++) begin : g_pk
    assign in_data[s*W +: W] = d[s];
  end

  scatter_engine #(.NP(NP), .W(W), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src), .done(done), .err(err));

  int checks = 0, errors = 0;
  logic [W-1:0] q [NP][NP][$];
  int cnt [NP], prv [NP];
  int done_cnt [NP], err_cnt [NP], done_cyc [NP], lastout_cyc [NP];
  int seq [$];
  int par_cycles = 0, cyc = 0;
  bit log_seq = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic xfer(input int s, input logic [W-1:0] w);
    @(negedge clk);
    v[s] = 1'b1; d[s] = w;
    while (!in_ready[s]) @(negedge clk);
  endtask

  task automatic submit(input int s, input logic [8:0] tags, input int sub);
    xfer(s, {7'd0, tags});
    for (int k = 0; k < NP-1; k++) begin
      int t;
      t = int'(tags[k*TW +: TW]);
      for (int w = 0; w < CW; w++) begin
        logic [W-1:0] x;
        x = {4'(s), 4'(sub), 4'(k), 4'(w)};
        xfer(s, x);
        if (t < NP && t != s) q[t][s].push_back(x);
      end
    end
    @(negedge clk);
    v[s] = 1'b0;
  endtask

  always @(negedge clk) begin
    int nv;
    cyc++;
    nv = 0;
    if (rst_n) begin
      for (int e = 0; e < NP; e++) begin
        if (out_valid[e]) begin
          int s;
          logic [W-1:0] x;
          nv++;
          s = int'(out_src[e*SW +: SW]);
          x = out_data[e*W +: W];
          lastout_cyc[s] = cyc;
          if (cnt[e] != 0) chk(s == prv[e], "R5 chunk interleaved", s, prv[e]);
          else if (log_seq && e == 2) seq.push_back(s);
          chk(int'(x[3:0]) == cnt[e], "R5 word position in run", int'(x[3:0]), cnt[e]);
          cnt[e] = (cnt[e] + 1) % CW;
          prv[e] = s;
          if (q[e][s].size() == 0) chk(0, "R4/R6 unexpected egress word", int'(x), -1);
          else begin
            logic [W-1:0] y;
            y = q[e][s].pop_front();
            chk(x == y, "R3 egress data", int'(x), int'(y));
          end
        end
      end
      for (int s = 0; s < NP; s++) begin
        if (done[s]) begin done_cnt[s]++; done_cyc[s] = cyc; end
        if (err[s]) err_cnt[s]++;
      end
      if (nv >= 2) par_cycles++;
    end
  end

  task automatic clear_counts();
    for (int s = 0; s < NP; s++) begin done_cnt[s] = 0; err_cnt[s] = 0; end
  endtask

  task automatic drained(input string tag);
    repeat (30) @(negedge clk);
    for (int e = 0; e < NP; e++)
      for (int s = 0; s < NP; s++)
        chk(q[e][s].size() == 0, {"R4 words left undelivered ", tag}, q[e][s].size(), 0);
  endtask

  function automatic logic [8:0] tg(input int a, input int b, input int c);
    return {3'(c), 3'(b), 3'(a)};
  endfunction

  initial begin
    for (int s = 0; s < NP; s++) begin
      d[s] = '0; cnt[s] = 0; prv[s] = 0; done_cyc[s] = 0; lastout_cyc[s] = 0;
    end
    clear_counts();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 4'hF, "R1 in_ready", int'(in_ready), 15);
    chk(done == 0 && err == 0, "R1 done/err", int'({done, err}), 0);
    rst_n = 1;

    // R2 R3 R8: rotating permutation, no egress conflicts
    fork
      submit(0, tg(1, 2, 3), 1);
      submit(1, tg(2, 3, 0), 1);
      submit(2, tg(3, 0, 1), 1);
      submit(3, tg(0, 1, 2), 1);
    join
    drained("perm");
    chk(par_cycles >= 3 * CW * 4 / 4, "R8 parallel egress cycles", par_cycles, 9);
    for (int s = 0; s < NP; s++) begin
      chk(done_cnt[s] == 1, "R7 done count", done_cnt[s], 1);
      chk(err_cnt[s] == 0, "R6 no error on valid tags", err_cnt[s], 0);
    end

    // R5 contention on egress 2
    clear_counts();
    log_seq = 1;
    fork
      submit(0, tg(2, 2, 2), 2);
      submit(1, tg(2, 2, 2), 2);
      submit(3, tg(2, 2, 2), 2);
    join
    drained("contend");
    log_seq = 0;
    chk(seq.size() == 9, "R5 chunk count on egress 2", seq.size(), 9);
    for (int i = 0; i < seq.size() && i < 9; i++) begin
      int ex;
      ex = (i % 3 == 2) ? 3 : (i % 3);
      chk(seq[i] == ex, "R5 round-robin order", seq[i], ex);
    end

    // R6 bad tags: self and out of range
    clear_counts();
    submit(0, tg(0, 1, 5), 3);
    drained("badtag");
    chk(err_cnt[0] == 2, "R6 error pulses", err_cnt[0], 2);
    chk(done_cnt[0] == 1, "R7 done after dropped chunk", done_cnt[0], 1);

    // R7 done timing vs last egress word
    clear_counts();
    submit(1, tg(0, 2, 3), 4);
    drained("timing");
    chk(done_cnt[1] == 1, "R7 single done", done_cnt[1], 1);
    chk(done_cyc[1] == lastout_cyc[1], "R7 done cycle", done_cyc[1], lastout_cyc[1]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule